// File: doc/BRIEF.md
# Double-Data-Rate Output and Tristate Cell

This block is the output side of one bidirectional pad. It takes two data bits and two tristate-control bits from the core, with a clock and a clock enable. It produces the value to drive and an active-low driver enable for the pad. Each of the two paths, data and tristate, is set at build time to one of three modes. In bypass mode the first line goes straight to the pad. In single-rate mode the first line is captured on the rising clock edge. In double-rate mode the first line is captured on the rising edge and the second on the falling edge, and a multiplexer steered by the clock level presents them in turn.

A build-time mask can invert each signal that enters the cell: both data lines, both tristate lines, the clock enable, the clock and the reset. The pad's input line is handed back to the core unchanged. All storage elements share an asynchronous reset, and each path has its own reset value.

Top module: `ocell_ddr_out`

## Requirements
- R1: While the effective reset is active, the stored bits of the data path hold DATA_RST (default 0) and those of the tristate path hold TRI_RST (default 1, pad released). This takes effect at once, without waiting for a clock edge.
- R2: In bypass mode a path's output follows its first input line (after the optional inversion) combinationally. The second line has no effect on it.
- R3: In single-rate mode a path's output changes only at the effective rising clock edge, and only when the effective enable is high. It then takes the first line's value from that edge. The second line has no effect on it.
- R4: In double-rate mode, while the effective clock is high, the output is the first line as captured at the latest enabled rising edge. While the effective clock is low, it is the second line as captured at the latest enabled falling edge.
- R5: The tristate path offers the same three modes as the data path and drives pad_oe_n_o. A value of 1 releases the pad to high impedance, and 0 drives pad_out_o onto it.
- R6: INV_MASK inverts individual inputs. Bit 0 inverts dat0_i, bit 1 dat1_i, bit 2 tri0_i, bit 3 tri1_i, bit 4 ce_i, bit 5 clk_i and bit 6 rst_i (set: reset active low). With bit 5 set, the rising edge of the cell is the falling edge of the pin.
- R7: core_in_o equals pad_in_i at all times.
- R8: When the effective enable is low at an edge, no register that the edge would load changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Cell clock (polarity per INV_MASK bit 5) |
| rst_i | input | 1 | Asynchronous reset (polarity per INV_MASK bit 6) |
| ce_i | input | 1 | Clock enable for all storage elements |
| dat0_i | input | 1 | First data line (rising-edge bit) |
| dat1_i | input | 1 | Second data line (falling-edge bit) |
| tri0_i | input | 1 | First tristate control line |
| tri1_i | input | 1 | Second tristate control line |
| pad_out_o | output | 1 | Value to drive onto the pad |
| pad_oe_n_o | output | 1 | Active-low pad driver enable |
| pad_in_i | input | 1 | Level sensed on the pad |
| core_in_o | output | 1 | Pad level returned to the core |

## Verification
A bypass result is due in the same time step as its input. A single-rate result is due just after the next effective rising edge. A double-rate bit is due just after the edge that starts its half-period. The bench changes inputs 2 ns after every clock edge and compares all outputs 7 ns after that edge, so every registered result has already settled and the next edge has not yet come. Three instances with different modes and inversion masks are each compared in every half-period against a behavioural model that updates on the pin clock edges. The pad is modelled as a resolved line: when the cell releases it, an external value drives it.

// File: rtl/ocell_pkg.sv
package ocell_pkg;

    typedef enum logic [1:0] {
        PM_BYPASS = 2'd0,
        PM_SDR    = 2'd1,
        PM_DDR    = 2'd2
    } path_mode_e;

    localparam int unsigned N_CTRL  = 7;
    localparam int unsigned B_DAT0  = 0;
    localparam int unsigned B_DAT1  = 1;
    localparam int unsigned B_TRI0  = 2;
    localparam int unsigned B_TRI1  = 3;
    localparam int unsigned B_CE    = 4;
    localparam int unsigned B_CLK   = 5;
    localparam int unsigned B_RST   = 6;
    localparam int unsigned N_LANES = 2;

    typedef struct packed {
        logic rise;
        logic fall;
    } lane_st_t;

endpackage

// File: rtl/ocell_pol.sv
module ocell_pol #(
    parameter int unsigned      N    = 7,
    parameter logic [N-1:0]     MASK = '0
) (
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] eff_o
);
    for (genvar k = 0; k < N; k++) begin : g_bit
        if (MASK[k]) begin : g_inv
            assign eff_o[k] = ~raw_i[k];
        end else begin : g_pass
            assign eff_o[k] = raw_i[k];
        end
    end
endmodule

// File: rtl/ocell_lane.sv
module ocell_lane
    import ocell_pkg::*;
#(
    parameter path_mode_e MODE    = PM_DDR,
    parameter logic       RST_VAL = 1'b0
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ce_i,
    input  logic a_i,
    input  logic b_i,
    output logic q_o
);
    lane_st_t st_d;
    logic     rise_q;
    logic     fall_q;

    always_comb begin
        st_d.rise = rise_q;
        st_d.fall = fall_q;
        if (ce_i) begin
            st_d.rise = a_i;
            st_d.fall = b_i;
        end
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) rise_q <= RST_VAL;
        else       rise_q <= st_d.rise;
    end

    always_ff @(negedge clk_i or posedge rst_i) begin
        if (rst_i) fall_q <= RST_VAL;
        else       fall_q <= st_d.fall;
    end

    always_comb begin
        case (MODE)
            PM_BYPASS: q_o = a_i;
            PM_SDR:    q_o = rise_q;
            default:   q_o = clk_i ? rise_q : fall_q;
        endcase
    end

    // R3: enabled rising edge loads the first line
    p_rise_load_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        ce_i |=> rise_q == $past(a_i));
    // R8: disabled rising edge keeps the stored bit
    p_rise_hold_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        !ce_i |=> $stable(rise_q));
    // R4: enabled falling edge loads the second line
    p_fall_load_r4: assert property (@(negedge clk_i) disable iff (rst_i)
        ce_i |=> fall_q == $past(b_i));
    // R8: disabled falling edge keeps the stored bit
    p_fall_hold_r8: assert property (@(negedge clk_i) disable iff (rst_i)
        !ce_i |=> $stable(fall_q));
endmodule

// File: rtl/ocell_ddr_out.sv
module ocell_ddr_out
    import ocell_pkg::*;
#(
    parameter path_mode_e         DATA_MODE = PM_DDR,
    parameter path_mode_e         TRI_MODE  = PM_DDR,
    parameter logic [N_CTRL-1:0]  INV_MASK  = '0,
    parameter logic               DATA_RST  = 1'b0,
    parameter logic               TRI_RST   = 1'b1
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic ce_i,
    input  logic dat0_i,
    input  logic dat1_i,
    input  logic tri0_i,
    input  logic tri1_i,
    output logic pad_out_o,
    output logic pad_oe_n_o,
    input  logic pad_in_i,
    output logic core_in_o
);
    logic [N_CTRL-1:0]  raw;
    logic [N_CTRL-1:0]  eff;
    logic [N_LANES-1:0] lane_a;
    logic [N_LANES-1:0] lane_b;
    logic [N_LANES-1:0] lane_q;

    assign raw[B_DAT0] = dat0_i;
    assign raw[B_DAT1] = dat1_i;
    assign raw[B_TRI0] = tri0_i;
    assign raw[B_TRI1] = tri1_i;
    assign raw[B_CE]   = ce_i;
    assign raw[B_CLK]  = clk_i;
    assign raw[B_RST]  = rst_i;

    ocell_pol #(.N(N_CTRL), .MASK(INV_MASK)) u_pol (
        .raw_i (raw),
        .eff_o (eff)
    );

    assign lane_a = {eff[B_TRI0], eff[B_DAT0]};
    assign lane_b = {eff[B_TRI1], eff[B_DAT1]};

    for (genvar g = 0; g < N_LANES; g++) begin : g_lane
        localparam path_mode_e LMODE = (g == 0) ? DATA_MODE : TRI_MODE;
        localparam logic       LRST  = (g == 0) ? DATA_RST  : TRI_RST;
        ocell_lane #(.MODE(LMODE), .RST_VAL(LRST)) u_lane (
            .clk_i (eff[B_CLK]),
            .rst_i (eff[B_RST]),
            .ce_i  (eff[B_CE]),
            .a_i   (lane_a[g]),
            .b_i   (lane_b[g]),
            .q_o   (lane_q[g])
        );
    end

    assign pad_out_o  = lane_q[0];
    assign pad_oe_n_o = lane_q[1];
    assign core_in_o  = pad_in_i;
endmodule

// File: tb/ocell_ddr_out_tb_top.sv
`timescale 1ns/1ps
module ocell_ddr_out_tb_top;
    import ocell_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce = 1'b1, d0 = 1'b0, d1 = 1'b0, t0 = 1'b1, t1 = 1'b1, ext = 1'b0;
    int   n_chk = 0, n_err = 0;

    always #10 clk = ~clk;

    logic o_i, oen_i, din_i, o_s, oen_s, din_s, o_b, oen_b, din_b;
    logic pad_line;
    assign pad_line = oen_i ? ext : o_i;   // resolved pad: external keeper when released

    // main: both paths double-rate, no inversion
    ocell_ddr_out #(.DATA_MODE(PM_DDR), .TRI_MODE(PM_DDR), .INV_MASK(7'b0000000)) dut_i (
        .clk_i(clk), .rst_i(rst), .ce_i(ce), .dat0_i(d0), .dat1_i(d1),
        .tri0_i(t0), .tri1_i(t1), .pad_out_o(o_i), .pad_oe_n_o(oen_i),
        .pad_in_i(pad_line), .core_in_o(din_i));

    // single-rate both paths; d0, t0, ce and clock inverted
    ocell_ddr_out #(.DATA_MODE(PM_SDR), .TRI_MODE(PM_SDR), .INV_MASK(7'b0110101)) dut_s (
        .clk_i(clk), .rst_i(rst), .ce_i(ce), .dat0_i(d0), .dat1_i(d1),
        .tri0_i(t0), .tri1_i(t1), .pad_out_o(o_s), .pad_oe_n_o(oen_s),
        .pad_in_i(ext), .core_in_o(din_s));

    // data bypass with d0 inverted, tristate single-rate, reset active low
    ocell_ddr_out #(.DATA_MODE(PM_BYPASS), .TRI_MODE(PM_SDR), .INV_MASK(7'b1000001)) dut_b (
        .clk_i(clk), .rst_i(~rst), .ce_i(ce), .dat0_i(d0), .dat1_i(d1),
        .tri0_i(t0), .tri1_i(t1), .pad_out_o(o_b), .pad_oe_n_o(oen_b),
        .pad_in_i(ext), .core_in_o(din_b));

    // behavioural reference
    logic m_hi_d, m_lo_d, m_hi_t, m_lo_t, ms_d, ms_t, mb_t;

    always @(posedge clk or posedge rst) begin
        if (rst) begin
            m_hi_d <= 1'b0; m_hi_t <= 1'b1; mb_t <= 1'b1;
        end else if (ce) begin
            m_hi_d <= d0; m_hi_t <= t0; mb_t <= t0;
        end
    end

    always @(negedge clk or posedge rst) begin
        if (rst) begin
            m_lo_d <= 1'b0; m_lo_t <= 1'b1; ms_d <= 1'b0; ms_t <= 1'b1;
        end else begin
            if (ce)  begin m_lo_d <= d1;  m_lo_t <= t1;  end
            if (!ce) begin ms_d   <= ~d0; ms_t   <= ~t0; end
        end
    end

    task automatic chk(input logic act, input logic exp, input string tag, input string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare();
        string td, tt, ts;
        td = rst ? "R1" : (!ce ? "R8" : "R4");
        tt = rst ? "R1" : "R5";
        ts = rst ? "R1" : "R6";
        chk(o_i,   clk ? m_hi_d : m_lo_d, td, "ddr data");
        chk(oen_i, clk ? m_hi_t : m_lo_t, tt, "ddr tristate");
        chk(din_i, pad_line, "R7", "core input");
        chk(din_b, ext,      "R7", "core input released");
        chk(o_s,   ms_d, rst ? "R1" : "R3", "sdr data inverted clock");
        chk(oen_s, ms_t, ts, "sdr tristate inverted t0/ce");
        chk(o_b,   ~d0,  "R2", "bypass data inverted d0");
        chk(oen_b, mb_t, ts, "sdr tristate low-active reset");
    endtask

    int step_no = 0;
    task automatic step(input logic r, input int mode);
        @(clk);
        #2;
        rst = r;
        d0 = 1'($urandom); d1 = 1'($urandom);
        t0 = 1'($urandom); t1 = 1'($urandom);
        ext = 1'($urandom);
        ce = (mode == 0) ? 1'b1 : (mode == 1) ? 1'b0 : 1'($urandom);
        #5;
        step_no++;
        if (step_no > 2) compare();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    endtask

    initial begin
        for (int i = 0; i < 6;  i++) step(1'b1, 0);
        for (int i = 0; i < 80; i++) step(1'b0, 0);
        for (int i = 0; i < 20; i++) step(1'b0, 1);
        for (int i = 0; i < 4;  i++) step(1'b1, 2);
        for (int i = 0; i < 80; i++) step(1'b0, 2);
        summary();
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual hung expected done");
        summary();
        $finish;
    end
endmodule